// File: doc/BRIEF.md
# Delayed Write Completion Parity Handler

This block sits on the initiator-facing port of a transparent bus bridge and finishes one delayed write. It holds the write at the front of the delayed-write queue: its address, command, 32-bit data word, byte enables and, once the far bus has executed it, the write status. When the original initiator repeats the write, the block checks the repeat against the held entry and checks the bus parity of the data phase. It answers with an active-low data-accept (`trdy_n`) or an active-low retry (`stop_n`), and raises an active-low parity-error strobe (`perr_n`) when an error has to be reported.

A write is taken in through a valid/ready stream. `ld_ready` is high only while the slot is empty, so a held entry back-pressures the queue behind it. The write status from the far side arrives as a one-cycle `done_valid` pulse. It also carries a flag saying whether the far-side target signalled a parity error while it took the data. The status is handed back on the `ret_valid`/`ret_stat` pulse when the write completes. That output has no ready: the initiator has already finished its bus transfer. Two sticky flags record initiator-side and far-side parity events. Each clears only on its own write-one-to-clear pulse. The two parity-response enables are plain level inputs.

Top module: `dwc_completion`

## Requirements
- R1: After the active-low synchronous reset, `trdy_n`, `stop_n` and `perr_n` are high, `ret_valid` is low, `ld_ready` is high, and both sticky flags are low.
- R2: `ld_ready` is high exactly when the slot is empty. A cycle with `ld_valid` and `ld_ready` both high loads the entry, and `ld_ready` is low from the next cycle until the entry completes.
- R3: A repeat whose address, command, data and byte enables all equal the held entry, arriving while the status is present, gets `trdy_n` low for one cycle. This is the cycle after the repeat's data phase. The parity bit takes no part in this comparison.
- R4: A repeat that differs in any compared field, arrives while the slot is empty or the status is absent, or arrives in the cycle right after another repeat, gets `stop_n` low for one cycle instead (same timing as R3). It changes neither the entry nor the sticky flags.
- R5: Data-phase parity is even over the 32 data bits and the 4 byte-enable bits. `rty_par` is sampled one cycle after the repeat's data phase (the `trdy_n`/`stop_n` cycle). An error means the XOR of data, byte enables and `rty_par` is 1.
- R6: On an accepted repeat with a parity error, `ini_pdet` is set, no status is returned and the entry stays held. `perr_n` goes low for exactly one cycle, two cycles after the `trdy_n` cycle, only if `ini_perr_en` is high.
- R7: On an accepted repeat without a parity error, `ret_valid` is high for one cycle, one cycle after the `trdy_n` cycle, with `ret_stat` equal to the stored status. In that same cycle the slot is empty and `ld_ready` is high.
- R8: If the status arrived with its far-side parity-error flag set, a clean accepted repeat still completes as in R7. `perr_n` also goes low for one cycle, two cycles after `trdy_n`, only when `ini_perr_en` and `tgt_perr_en` are both high.
- R9: A status pulse carrying a far-side parity error sets `tgt_dpd` when `tgt_perr_en` is high. With `tgt_perr_en` low it leaves `tgt_dpd` unchanged.
- R10: Both flags are sticky. Each is cleared only by a one-cycle pulse on its own clear input, and a set in the same cycle wins over the clear.
- R11: A `done_valid` pulse is taken only while an entry is held without status. Otherwise it changes neither the stored status nor `tgt_dpd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | New head entry offered |
| ld_ready | output | 1 | Slot empty, entry can be taken |
| ld_addr | input | 32 | Entry address |
| ld_cmd | input | 4 | Entry bus command |
| ld_data | input | 32 | Entry write data |
| ld_be | input | 4 | Entry byte enables |
| done_valid | input | 1 | Write status from far side, one-cycle pulse |
| done_stat | input | 2 | Write status value |
| done_tperr | input | 1 | Far-side target reported a parity error |
| rty_valid | input | 1 | Data phase of an initiator repeat |
| rty_addr | input | 32 | Repeat address |
| rty_cmd | input | 4 | Repeat command |
| rty_data | input | 32 | Repeat data |
| rty_be | input | 4 | Repeat byte enables |
| rty_par | input | 1 | Parity of the repeat data phase, one cycle late |
| ini_perr_en | input | 1 | Initiator-side parity error response enable |
| tgt_perr_en | input | 1 | Far-side parity error response enable |
| clr_ini_pdet | input | 1 | Write-one-to-clear for ini_pdet |
| clr_tgt_dpd | input | 1 | Write-one-to-clear for tgt_dpd |
| trdy_n | output | 1 | Active-low data accepted |
| stop_n | output | 1 | Active-low retry response |
| perr_n | output | 1 | Active-low parity error strobe |
| ret_valid | output | 1 | Status returned, one-cycle pulse |
| ret_stat | output | 2 | Returned write status |
| ini_pdet | output | 1 | Sticky initiator-side parity error detected |
| tgt_dpd | output | 1 | Sticky far-side data parity detected |

## Verification
The bench builds the block with its default widths: 32-bit address and data, 4-bit command, 2-bit status. With these, the even-parity rule covers exactly 36 bits, so a single flipped parity bit on an otherwise matching repeat shows both that parity is left out of the match and that it drives the error path. A 2-bit status lets a second, ignored status pulse carry a value different from the first, so it can be told apart at `ret_stat`. Back-to-back repeats and each combination of the two response enables are exercised on the same held entry, and expected strobe cycles are counted from the repeat's data phase.

// File: rtl/dwc_pkg.sv
package dwc_pkg;
  // response chosen in the cycle after a repeat data phase
  typedef enum logic [1:0] {
    RSP_NONE  = 2'd0,
    RSP_DATA  = 2'd1,
    RSP_RETRY = 2'd2
  } rsp_e;

  // clocks between the data-accept cycle and the parity-error strobe
  localparam int PERR_LAG = 2;
endpackage

// File: rtl/dwc_head_slot.sv
module dwc_head_slot #(
  parameter int AW = 32,
  parameter int CW = 4,
  parameter int DW = 32,
  parameter int SW = 2,
  localparam int BEW = DW / 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ld_valid,
  output logic           ld_ready,
  input  logic [AW-1:0]  ld_addr,
  input  logic [CW-1:0]  ld_cmd,
  input  logic [DW-1:0]  ld_data,
  input  logic [BEW-1:0] ld_be,
  input  logic           done_valid,
  input  logic [SW-1:0]  done_stat,
  input  logic           done_tperr,
  input  logic           tgt_perr_en,
  input  logic           pop,
  output logic           slot_full,
  output logic           stat_rdy,
  output logic [SW-1:0]  h_stat,
  output logic           h_fwd,
  output logic [AW-1:0]  h_addr,
  output logic [CW-1:0]  h_cmd,
  output logic [DW-1:0]  h_data,
  output logic [BEW-1:0] h_be,
  output logic           tgt_set
);
  logic take_ld, take_done;

  assign ld_ready  = !slot_full;
  assign take_ld   = ld_valid && !slot_full;
  assign take_done = done_valid && slot_full && !stat_rdy;
  assign tgt_set   = take_done && done_tperr && tgt_perr_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_full <= 1'b0;
      stat_rdy  <= 1'b0;
      h_stat    <= '0;
      h_fwd     <= 1'b0;
      h_addr    <= '0;
      h_cmd     <= '0;
      h_data    <= '0;
      h_be      <= '0;
    end else if (pop) begin
      slot_full <= 1'b0;
      stat_rdy  <= 1'b0;
      h_fwd     <= 1'b0;
    end else if (take_ld) begin
      slot_full <= 1'b1;
      stat_rdy  <= 1'b0;
      h_fwd     <= 1'b0;
      h_addr    <= ld_addr;
      h_cmd     <= ld_cmd;
      h_data    <= ld_data;
      h_be      <= ld_be;
    end else if (take_done) begin
      stat_rdy  <= 1'b1;
      h_stat    <= done_stat;
      h_fwd     <= done_tperr;
    end
  end
endmodule

// File: rtl/dwc_retry_front.sv
module dwc_retry_front
  import dwc_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 4,
  parameter int DW = 32,
  localparam int BEW = DW / 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rty_valid,
  input  logic [AW-1:0]  rty_addr,
  input  logic [CW-1:0]  rty_cmd,
  input  logic [DW-1:0]  rty_data,
  input  logic [BEW-1:0] rty_be,
  input  logic           slot_full,
  input  logic           stat_rdy,
  input  logic [AW-1:0]  h_addr,
  input  logic [CW-1:0]  h_cmd,
  input  logic [DW-1:0]  h_data,
  input  logic [BEW-1:0] h_be,
  output rsp_e           s1_rsp,
  output logic [DW-1:0]  s1_data,
  output logic [BEW-1:0] s1_be,
  output logic           trdy_n,
  output logic           stop_n
);
  logic busy, same, hit_now;

  // a repeat still being answered blocks the next one
  assign busy    = (s1_rsp != RSP_NONE);
  assign same    = slot_full && (rty_addr == h_addr) && (rty_cmd == h_cmd)
                && (rty_data == h_data) && (rty_be == h_be);
  assign hit_now = rty_valid && !busy && same && stat_rdy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_rsp  <= RSP_NONE;
      s1_data <= '0;
      s1_be   <= '0;
    end else begin
      if (!rty_valid)   s1_rsp <= RSP_NONE;
      else if (hit_now) s1_rsp <= RSP_DATA;
      else              s1_rsp <= RSP_RETRY;
      s1_data <= rty_data;
      s1_be   <= rty_be;
    end
  end

  assign trdy_n = (s1_rsp != RSP_DATA);
  assign stop_n = (s1_rsp != RSP_RETRY);
endmodule

// File: rtl/dwc_perr_pipe.sv
module dwc_perr_pipe
  import dwc_pkg::*;
#(
  parameter int DW = 32,
  parameter int SW = 2,
  localparam int BEW = DW / 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  rsp_e           s1_rsp,
  input  logic [DW-1:0]  s1_data,
  input  logic [BEW-1:0] s1_be,
  input  logic           rty_par,
  input  logic           h_fwd,
  input  logic [SW-1:0]  h_stat,
  input  logic           ini_perr_en,
  input  logic           tgt_perr_en,
  output logic           pop,
  output logic           ini_set,
  output logic           ret_valid,
  output logic [SW-1:0]  ret_stat,
  output logic           perr_n
);
  logic accepted, par_err, raise;
  logic [PERR_LAG-1:0] lag;

  assign accepted = (s1_rsp == RSP_DATA);
  assign par_err  = ^{s1_data, s1_be, rty_par};
  assign pop      = accepted && !par_err;
  assign ini_set  = accepted && par_err;
  assign raise    = accepted && (par_err ? ini_perr_en
                                         : (h_fwd && ini_perr_en && tgt_perr_en));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ret_valid <= 1'b0;
      ret_stat  <= '0;
    end else begin
      ret_valid <= pop;
      if (pop) ret_stat <= h_stat;
    end
  end

  for (genvar g = 0; g < PERR_LAG; g++) begin : g_lag
    always_ff @(posedge clk) begin
      if (!rst_n)      lag[g] <= 1'b0;
      else if (g == 0) lag[g] <= raise;
      else             lag[g] <= lag[(g == 0) ? 0 : g-1];
    end
  end

  assign perr_n = ~lag[PERR_LAG-1];
endmodule

// File: rtl/dwc_completion.sv
module dwc_completion
  import dwc_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 4,
  parameter int DW = 32,
  parameter int SW = 2,
  localparam int BEW = DW / 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ld_valid,
  output logic           ld_ready,
  input  logic [AW-1:0]  ld_addr,
  input  logic [CW-1:0]  ld_cmd,
  input  logic [DW-1:0]  ld_data,
  input  logic [BEW-1:0] ld_be,
  input  logic           done_valid,
  input  logic [SW-1:0]  done_stat,
  input  logic           done_tperr,
  input  logic           rty_valid,
  input  logic [AW-1:0]  rty_addr,
  input  logic [CW-1:0]  rty_cmd,
  input  logic [DW-1:0]  rty_data,
  input  logic [BEW-1:0] rty_be,
  input  logic           rty_par,
  input  logic           ini_perr_en,
  input  logic           tgt_perr_en,
  input  logic           clr_ini_pdet,
  input  logic           clr_tgt_dpd,
  output logic           trdy_n,
  output logic           stop_n,
  output logic           perr_n,
  output logic           ret_valid,
  output logic [SW-1:0]  ret_stat,
  output logic           ini_pdet,
  output logic           tgt_dpd
);
  logic           slot_full, stat_rdy, h_fwd, pop, ini_set, tgt_set;
  logic [SW-1:0]  h_stat;
  logic [AW-1:0]  h_addr;
  logic [CW-1:0]  h_cmd;
  logic [DW-1:0]  h_data;
  logic [BEW-1:0] h_be;
  rsp_e           s1_rsp;
  logic [DW-1:0]  s1_data;
  logic [BEW-1:0] s1_be;

  dwc_head_slot #(.AW(AW), .CW(CW), .DW(DW), .SW(SW)) u_slot (
    .clk(clk), .rst_n(rst_n),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr), .ld_cmd(ld_cmd),
    .ld_data(ld_data), .ld_be(ld_be),
    .done_valid(done_valid), .done_stat(done_stat), .done_tperr(done_tperr),
    .tgt_perr_en(tgt_perr_en), .pop(pop),
    .slot_full(slot_full), .stat_rdy(stat_rdy), .h_stat(h_stat), .h_fwd(h_fwd),
    .h_addr(h_addr), .h_cmd(h_cmd), .h_data(h_data), .h_be(h_be), .tgt_set(tgt_set)
  );

  dwc_retry_front #(.AW(AW), .CW(CW), .DW(DW)) u_front (
    .clk(clk), .rst_n(rst_n),
    .rty_valid(rty_valid), .rty_addr(rty_addr), .rty_cmd(rty_cmd),
    .rty_data(rty_data), .rty_be(rty_be),
    .slot_full(slot_full), .stat_rdy(stat_rdy),
    .h_addr(h_addr), .h_cmd(h_cmd), .h_data(h_data), .h_be(h_be),
    .s1_rsp(s1_rsp), .s1_data(s1_data), .s1_be(s1_be),
    .trdy_n(trdy_n), .stop_n(stop_n)
  );

  dwc_perr_pipe #(.DW(DW), .SW(SW)) u_perr (
    .clk(clk), .rst_n(rst_n),
    .s1_rsp(s1_rsp), .s1_data(s1_data), .s1_be(s1_be), .rty_par(rty_par),
    .h_fwd(h_fwd), .h_stat(h_stat),
    .ini_perr_en(ini_perr_en), .tgt_perr_en(tgt_perr_en),
    .pop(pop), .ini_set(ini_set),
    .ret_valid(ret_valid), .ret_stat(ret_stat), .perr_n(perr_n)
  );

  // sticky flags: a set in the same cycle wins over the clear
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ini_pdet <= 1'b0;
      tgt_dpd  <= 1'b0;
    end else begin
      if (ini_set)           ini_pdet <= 1'b1;
      else if (clr_ini_pdet) ini_pdet <= 1'b0;
      if (tgt_set)           tgt_dpd  <= 1'b1;
      else if (clr_tgt_dpd)  tgt_dpd  <= 1'b0;
    end
  end
endmodule

// File: rtl/dwc_completion_chk.sv
module dwc_completion_chk (
  input logic clk,
  input logic rst_n,
  input logic ld_valid,
  input logic ld_ready,
  input logic done_valid,
  input logic done_tperr,
  input logic tgt_perr_en,
  input logic clr_ini_pdet,
  input logic trdy_n,
  input logic stop_n,
  input logic perr_n,
  input logic ret_valid,
  input logic ini_pdet,
  input logic tgt_dpd
);
  // R3/R4: one response per repeat, never both
  assert_one_response_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!trdy_n && !stop_n));

  // R2: a taken load fills the slot
  assert_load_fills_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_ready) |=> !ld_ready);

  // R6/R8: the parity strobe trails a data accept by two cycles
  assert_perr_after_trdy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_n |-> $past(!trdy_n, 2));

  // R6: the strobe lasts one cycle
  assert_perr_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_n |=> perr_n);

  // R7: status returns only right after a data accept
  assert_ret_after_trdy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |-> $past(!trdy_n));

  // R7: completion frees the slot
  assert_ret_frees_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |-> ld_ready);

  // R10: initiator-side flag holds until cleared
  assert_ini_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ini_pdet && !clr_ini_pdet) |=> ini_pdet);

  // R9: far-side flag rises only from an enabled error report
  assert_tgt_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tgt_dpd) |-> $past(done_valid && done_tperr && tgt_perr_en));
endmodule

bind dwc_completion dwc_completion_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
  .done_valid(done_valid), .done_tperr(done_tperr), .tgt_perr_en(tgt_perr_en),
  .clr_ini_pdet(clr_ini_pdet), .trdy_n(trdy_n), .stop_n(stop_n), .perr_n(perr_n),
  .ret_valid(ret_valid), .ini_pdet(ini_pdet), .tgt_dpd(tgt_dpd)
);

// File: tb/tb_dwc_completion.sv
module tb_dwc_completion;
  localparam int AW = 32, CW = 4, DW = 32, SW = 2, BEW = DW / 8;
  localparam int K_STOP = 0, K_TRDY = 1, K_RET = 2, K_PERR = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ld_valid = 0, done_valid = 0, done_tperr = 0, rty_valid = 0, rty_par = 0;
  logic ini_perr_en = 1, tgt_perr_en = 1, clr_ini_pdet = 0, clr_tgt_dpd = 0;
  logic [AW-1:0] ld_addr = 0, rty_addr = 0;
  logic [CW-1:0] ld_cmd = 0, rty_cmd = 0;
  logic [DW-1:0] ld_data = 0, rty_data = 0;
  logic [BEW-1:0] ld_be = 0, rty_be = 0;
  logic [SW-1:0] done_stat = 0;
  logic ld_ready, trdy_n, stop_n, perr_n, ret_valid, ini_pdet, tgt_dpd;
  logic [SW-1:0] ret_stat;

  always #4 clk = ~clk;

  dwc_completion #(.AW(AW), .CW(CW), .DW(DW), .SW(SW)) dut (.*);

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_cmp = 0, n_bad = 0;
  bit fin = 0;

  // scoreboard queues of expected output events
  int    exp_kind[$];
  int    exp_cyc[$];
  int    exp_stat[$];
  string exp_tag[$];

  // bench model of the held entry
  bit m_full = 0, m_rdy = 0, m_fwd = 0, m_ini = 0, m_tgt = 0;
  logic [AW-1:0] m_addr; logic [CW-1:0] m_cmd; logic [DW-1:0] m_data; logic [BEW-1:0] m_be;
  int m_stat = 0;

  task automatic push(input int k, input int c, input int s, input string t);
    exp_kind.push_back(k); exp_cyc.push_back(c); exp_stat.push_back(s); exp_tag.push_back(t);
  endtask

  function automatic string kname(input int k);
    case (k) K_STOP: return "stop"; K_TRDY: return "trdy"; K_RET: return "ret"; default: return "perr"; endcase
  endfunction

  function automatic string ktag(input int k);
    case (k) K_STOP: return "R4"; K_TRDY: return "R3"; K_RET: return "R7"; default: return "R6"; endcase
  endfunction

  task automatic observe(input int k, input int s);
    n_cmp++;
    if (exp_kind.size() > 0 && exp_cyc[0] == cyc && exp_kind[0] == k) begin
      if (k == K_RET && exp_stat[0] != s) begin
        n_bad++;
        $display("FAIL %s ret_stat actual %0d expected %0d (cycle %0d)", exp_tag[0], s, exp_stat[0], cyc);
      end
      void'(exp_kind.pop_front()); void'(exp_cyc.pop_front());
      void'(exp_stat.pop_front()); void'(exp_tag.pop_front());
    end else begin
      n_bad++;
      $display("FAIL %s unexpected %s actual at cycle %0d expected %s", ktag(k), kname(k), cyc,
               (exp_kind.size() > 0) ? $sformatf("%s at %0d", kname(exp_kind[0]), exp_cyc[0]) : "none");
    end
  endtask

  // monitor: pops and compares as outputs appear
  always @(negedge clk) begin
    if (rst_n && !fin) begin
      while (exp_kind.size() > 0 && exp_cyc[0] < cyc) begin
        n_cmp++; n_bad++;
        $display("FAIL %s %s actual absent expected at cycle %0d", exp_tag[0], kname(exp_kind[0]), exp_cyc[0]);
        void'(exp_kind.pop_front()); void'(exp_cyc.pop_front());
        void'(exp_stat.pop_front()); void'(exp_tag.pop_front());
      end
      if (!stop_n)   observe(K_STOP, 0);
      if (!trdy_n)   observe(K_TRDY, 0);
      if (ret_valid) observe(K_RET, int'(ret_stat));
      if (!perr_n)   observe(K_PERR, 0);
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic load(input logic [AW-1:0] a, input logic [CW-1:0] c,
                      input logic [DW-1:0] d, input logic [BEW-1:0] b);
    @(negedge clk);
    chk("R2", "ld_ready before load", int'(ld_ready), int'(!m_full));
    ld_valid = 1; ld_addr = a; ld_cmd = c; ld_data = d; ld_be = b;
    if (!m_full) begin
      m_full = 1; m_rdy = 0; m_fwd = 0; m_addr = a; m_cmd = c; m_data = d; m_be = b;
    end
    @(negedge clk);
    ld_valid = 0;
    chk("R2", "ld_ready after load", int'(ld_ready), 0);
  endtask

  task automatic complete(input int s, input bit tp);
    @(negedge clk);
    done_valid = 1; done_stat = SW'(s); done_tperr = tp;
    if (m_full && !m_rdy) begin
      m_rdy = 1; m_stat = s; m_fwd = tp;
      if (tp && tgt_perr_en) m_tgt = 1;
    end
    @(negedge clk);
    done_valid = 0; done_tperr = 0;
  endtask

  task automatic retry(input logic [AW-1:0] a, input logic [CW-1:0] c,
                       input logic [DW-1:0] d, input logic [BEW-1:0] b, input bit bad);
    int c0; bit hit;
    @(negedge clk);
    c0 = cyc;
    hit = m_full && m_rdy && a == m_addr && c == m_cmd && d == m_data && b == m_be;
    rty_valid = 1; rty_addr = a; rty_cmd = c; rty_data = d; rty_be = b;
    if (hit) begin
      push(K_TRDY, c0 + 1, 0, "R3");
      if (bad) begin
        m_ini = 1;
        if (ini_perr_en) push(K_PERR, c0 + 3, 0, "R6");
      end else begin
        push(K_RET, c0 + 2, m_stat, "R7");
        if (m_fwd && ini_perr_en && tgt_perr_en) push(K_PERR, c0 + 3, 0, "R8");
        m_full = 0; m_rdy = 0; m_fwd = 0;
      end
    end else push(K_STOP, c0 + 1, 0, "R4");
    @(negedge clk);
    rty_valid = 0; rty_par = (^{d, b}) ^ bad;   // R5 even parity, one cycle late
    @(negedge clk);
    rty_par = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic clr_ini();
    @(negedge clk); clr_ini_pdet = 1;
    @(negedge clk); clr_ini_pdet = 0; m_ini = 0;
  endtask

  task automatic clr_tgt();
    @(negedge clk); clr_tgt_dpd = 1;
    @(negedge clk); clr_tgt_dpd = 0; m_tgt = 0;
  endtask

  task automatic flags(input string tag);
    chk(tag, "ini_pdet", int'(ini_pdet), int'(m_ini));
    chk(tag, "tgt_dpd", int'(tgt_dpd), int'(m_tgt));
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      fin = 1; n_cmp++; n_bad++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int c0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "trdy_n", int'(trdy_n), 1);
    chk("R1", "stop_n", int'(stop_n), 1);
    chk("R1", "perr_n", int'(perr_n), 1);
    chk("R1", "ret_valid", int'(ret_valid), 0);
    chk("R1", "ld_ready", int'(ld_ready), 1);
    flags("R1");

    // R4: repeat with an empty slot
    retry(32'h1000_0040, 4'h7, 32'hCAFE_0001, 4'hF, 0);

    // R2 load, then R4 repeat before status arrives
    load(32'h1000_0040, 4'h7, 32'hCAFE_0001, 4'hF);
    retry(32'h1000_0040, 4'h7, 32'hCAFE_0001, 4'hF, 0);

    complete(2, 0);
    // R11: extra status pulse is ignored (value and error flag)
    complete(3, 1);
    flags("R11");

    // R4: mismatching data with bad parity changes nothing
    retry(32'h1000_0040, 4'h7, 32'hCAFE_0003, 4'hF, 1);
    retry(32'h1000_0044, 4'h7, 32'hCAFE_0001, 4'hF, 0);
    retry(32'h1000_0040, 4'h7, 32'hCAFE_0001, 4'h3, 0);
    flags("R4");

    // R3 + R5 + R6: matching repeat with wrong parity
    retry(32'h1000_0040, 4'h7, 32'hCAFE_0001, 4'hF, 1);
    flags("R6");
    chk("R6", "ld_ready (entry kept)", int'(ld_ready), 0);

    // R7: clean repeat completes with the first status (R11 value 2)
    retry(32'h1000_0040, 4'h7, 32'hCAFE_0001, 4'hF, 0);
    chk("R7", "ld_ready after completion", int'(ld_ready), 1);

    // R10: flag stays, then clears on pulse
    repeat (4) @(negedge clk);
    flags("R10");
    clr_ini();
    flags("R10");

    // R9 + R8: forwarded far-side error, both enables on
    load(32'h2000_0000, 4'h3, 32'h0F0F_1234, 4'h5);
    complete(1, 1);
    flags("R9");
    retry(32'h2000_0000, 4'h3, 32'h0F0F_1234, 4'h5, 0);
    clr_tgt();
    flags("R10");

    // R8/R9: far-side enable off: no flag, no strobe, still completes
    tgt_perr_en = 0;
    load(32'h3000_0010, 4'hB, 32'h8000_0001, 4'h8);
    complete(3, 1);
    flags("R9");
    retry(32'h3000_0010, 4'hB, 32'h8000_0001, 4'h8, 0);
    tgt_perr_en = 1;

    // R6: initiator enable off: flag set, no strobe, entry kept
    ini_perr_en = 0;
    load(32'h4000_0020, 4'h7, 32'h1234_5678, 4'hC);
    complete(0, 0);
    retry(32'h4000_0020, 4'h7, 32'h1234_5678, 4'hC, 1);
    flags("R6");
    chk("R6", "ld_ready (entry kept, enable off)", int'(ld_ready), 0);
    ini_perr_en = 1;
    clr_ini();

    // R4: back-to-back repeats, second one answered with retry
    @(negedge clk);
    c0 = cyc;
    rty_valid = 1; rty_addr = m_addr; rty_cmd = m_cmd; rty_data = m_data; rty_be = m_be;
    push(K_TRDY, c0 + 1, 0, "R3");
    push(K_STOP, c0 + 2, 0, "R4");
    push(K_PERR, c0 + 3, 0, "R6");
    m_ini = 1;
    @(negedge clk);
    rty_par = ~(^{m_data, m_be});
    @(negedge clk);
    rty_valid = 0; rty_par = 0;
    repeat (4) @(negedge clk);
    flags("R6");

    // final clean completion of the held entry
    retry(m_addr, m_cmd, m_data, m_be, 0);
    chk("R7", "ld_ready at end", int'(ld_ready), 1);

    repeat (4) @(negedge clk);
    fin = 1;
    while (exp_kind.size() > 0) begin
      n_cmp++; n_bad++;
      $display("FAIL %s %s actual absent expected at cycle %0d", exp_tag[0], kname(exp_kind[0]), exp_cyc[0]);
      void'(exp_kind.pop_front()); void'(exp_cyc.pop_front());
      void'(exp_stat.pop_front()); void'(exp_tag.pop_front());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule